// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block derives the bit-rate timing pulse for a serial transmitter and receiver from the system clock. The division has two stages. A power-of-two prescaler divides the system clock by 2^N, where N is 0 to 11, and produces the basic clock tick. An 8-bit programmable counter then divides the basic tick by its value, and a final toggle stage halves the result. The bit tick therefore arrives once every 2 × count × 2^N system clock cycles. The prescaler choice should keep the basic tick at or below 25 MHz for the system clock in use.

Software writes the prescaler exponent, the counter value and a run bit through a byte-wide register port. Any read returns the stored value. Writing either divider register restarts both stages from zero. Changing the run bit does the same. After a restart, the `ready` output stays low until two basic-clock periods have elapsed. The shift logic should not enable its transmitter or receiver before `ready` is high. Clearing the run bit stops the generator.

Top module: `uart_rate_gen`

## Requirements
- R1: After reset, `basicTick`, `bitTick` and `ready` are low. The readback values are run = 0 at address 0, exponent = 0 at address 1, and count = 8 at address 2.
- R2: While running with exponent N, `basicTick` is a one-cycle pulse that repeats every 2^N system clock cycles. After a restart, the first pulse is seen 2^N + 1 cycles after the write edge.
- R3: While running, `bitTick` pulses for one cycle once every 2 × count × 2^N cycles, and always in the same cycle as a `basicTick` pulse.
- R4: A write to address 1 takes the exponent from bits 3:0 and ignores bits 7:4. A value above 11 is stored and read back as 11.
- R5: A write to address 2 stores the count. A value below 8 is stored and read back as 8. Values from 8 to 255 are kept as written.
- R6: Any write to address 1 or 2 restarts both stages from zero, including a write of an unchanged value. The same holds for a write to address 0 that changes bit 0 (run). In the next cycle both ticks and `ready` are low.
- R7: With run = 0, neither tick pulses and `ready` is low.
- R8: `ready` rises only after two `basicTick` pulses have been seen since the last restart, and only while running.
- R9: A write to address 3 changes nothing, and address 3 reads as 0. A write to address 0 that keeps the run bit unchanged does not restart the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Register address (0 run, 1 exponent, 2 count, 3 unused) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| basicTick | output | 1 | Prescaler output pulse |
| bitTick | output | 1 | Bit-rate pulse |
| ready | output | 1 | Settle interval complete since the last restart |

## Verification
The hardest situation to reach is the largest exponent, where a single bit period takes 32768 cycles. There, the first bit tick and the point where `ready` rises must both be counted exactly from the restart edge. The stimulus writes exponent 15 so that it clamps to 11. It then counts cycles to the first bit tick while the reference model follows every cycle. A second hard case is a restart in the middle of a period. The stimulus reaches it by rewriting an unchanged count while ticks are flowing. It also rewrites the run bit with its current value, to show that this alone does not restart the stages.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;
  parameter int DATA_W = 8;
  parameter int ADDR_W = 2;
  parameter int SEL_W = 4;
  parameter int CNT_W = 8;
  parameter int SEL_TOP = 11;
  parameter int CNT_LOW = 8;
  parameter int SETTLE_TICKS = 2;

  localparam int PRE_W = SEL_TOP;
  localparam int SETTLE_W = $clog2(SETTLE_TICKS + 1);

  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(SEL_TOP);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(CNT_LOW);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(2);

  typedef struct packed {
    logic restart;
    logic run;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] count;
  } rateCtl_t;
endpackage

// File: rtl/uart_rate_ctrl.sv
module uart_rate_ctrl
  import uart_rate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic basicTick,
  output logic [DATA_W-1:0] regRdData,
  output rateCtl_t ctl,
  output logic ready
);
  logic runQ;
  logic [SEL_W-1:0] selQ;
  logic [CNT_W-1:0] cntQ;
  logic [SETTLE_W-1:0] settleQ;
  logic restart;
  logic [SEL_W-1:0] selIn;
  logic [CNT_W-1:0] cntIn;

  // Clamp incoming values to the legal range before storing them
  assign selIn = (regWrData[SEL_W-1:0] > SEL_MAX) ? SEL_MAX : regWrData[SEL_W-1:0];
  assign cntIn = (regWrData[CNT_W-1:0] < CNT_MIN) ? CNT_MIN : regWrData[CNT_W-1:0];

  // A divider write, or a real change of the run bit, restarts both stages
  always_comb begin
    restart = 1'b0;
    if (regWrEn) begin
      if (regAddr == SEL_ADDR || regAddr == CNT_ADDR)
        restart = 1'b1;
      else if (regAddr == CTRL_ADDR && regWrData[0] != runQ)
        restart = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ <= 1'b0;
      selQ <= '0;
      cntQ <= CNT_MIN;
    end else if (regWrEn) begin
      case (regAddr)
        CTRL_ADDR: runQ <= regWrData[0];
        SEL_ADDR:  selQ <= selIn;
        CNT_ADDR:  cntQ <= cntIn;
        default:   ;
      endcase
    end
  end

  // Settle counter: counts basic ticks after a restart, saturates at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      settleQ <= '0;
    else if (restart)
      settleQ <= '0;
    else if (runQ && basicTick && settleQ != SETTLE_W'(SETTLE_TICKS))
      settleQ <= settleQ + SETTLE_W'(1);
  end

  assign ready = runQ && (settleQ == SETTLE_W'(SETTLE_TICKS));

  always_comb begin
    case (regAddr)
      CTRL_ADDR: regRdData = {{(DATA_W-1){1'b0}}, runQ};
      SEL_ADDR:  regRdData = DATA_W'(selQ);
      CNT_ADDR:  regRdData = DATA_W'(cntQ);
      default:   regRdData = '0;
    endcase
  end

  assign ctl.restart = restart;
  assign ctl.run = runQ;
  assign ctl.sel = selQ;
  assign ctl.count = cntQ;
endmodule

// File: rtl/uart_rate_dp.sv
module uart_rate_dp
  import uart_rate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  rateCtl_t ctl,
  output logic basicTick,
  output logic bitTick
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] divCnt;
  logic halfQ;
  logic [PRE_W:0] preSpan;
  logic preWrap;
  logic divWrap;
  logic hold;

  // Prescaler wraps after 2^sel cycles
  assign preSpan = (PRE_W+1)'(1) << ctl.sel;
  assign preWrap = ({1'b0, preCnt} == (preSpan - (PRE_W+1)'(1)));
  assign divWrap = (divCnt == (ctl.count - CNT_W'(1)));
  assign hold = ctl.restart || !ctl.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      basicTick <= 1'b0;
    end else if (hold) begin
      preCnt <= '0;
      basicTick <= 1'b0;
    end else begin
      preCnt <= preWrap ? '0 : preCnt + PRE_W'(1);
      basicTick <= preWrap;
    end
  end

  // Count divider, followed by a halving toggle stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      halfQ <= 1'b0;
      bitTick <= 1'b0;
    end else if (hold) begin
      divCnt <= '0;
      halfQ <= 1'b0;
      bitTick <= 1'b0;
    end else if (preWrap) begin
      if (divWrap) begin
        divCnt <= '0;
        halfQ <= ~halfQ;
        bitTick <= halfQ;
      end else begin
        divCnt <= divCnt + CNT_W'(1);
        bitTick <= 1'b0;
      end
    end else begin
      bitTick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen
  import uart_rate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic basicTick,
  output logic bitTick,
  output logic ready
);
  rateCtl_t ctl;

  uart_rate_ctrl ctrl_i (
    .clk(clk),
    .rst_n(rst_n),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .regWrData(regWrData),
    .basicTick(basicTick),
    .regRdData(regRdData),
    .ctl(ctl),
    .ready(ready)
  );

  uart_rate_dp dp_i (
    .clk(clk),
    .rst_n(rst_n),
    .ctl(ctl),
    .basicTick(basicTick),
    .bitTick(bitTick)
  );
endmodule

// File: rtl/uart_rate_chk.sv
module uart_rate_chk
  import uart_rate_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic basicTick,
  input logic bitTick,
  input logic ready,
  input rateCtl_t ctl
);
  // R3
  bit_with_basic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitTick |-> basicTick);

  // R2
  basic_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (basicTick && ctl.sel != '0) |=> !basicTick);

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && (regAddr == SEL_ADDR || regAddr == CNT_ADDR)) |=> (!basicTick && !bitTick && !ready));

  // R7
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.run |=> (!basicTick && !bitTick));

  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(basicTick));

  // R4
  sel_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.sel <= SEL_MAX);

  // R5
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.count >= CNT_MIN);
endmodule

bind uart_rate_gen uart_rate_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .regWrEn(regWrEn),
  .regAddr(regAddr),
  .basicTick(basicTick),
  .bitTick(bitTick),
  .ready(ready),
  .ctl(ctl)
);

// File: tb/uart_rate_gen_tb_top.sv
module uart_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic basicTick, bitTick, ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .basicTick(basicTick), .bitTick(bitTick), .ready(ready)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit compareOn = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mPre = 0, mDiv = 0, mSettle = 0, mSel = 0, mCnt = 8;
  bit mHalf = 0, mBasic = 0, mBit = 0, mRun = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPre = 0; mDiv = 0; mSettle = 0; mSel = 0; mCnt = 8;
      mHalf = 0; mBasic = 0; mBit = 0; mRun = 0;
    end else begin : step
      bit rs, strobe, oldBasic;
      int wsel, wcnt;
      compareOn = 1'b1;
      oldBasic = mBasic;
      rs = regWrEn && (regAddr == 2'd1 || regAddr == 2'd2 ||
                       (regAddr == 2'd0 && regWrData[0] != mRun));
      if (rs || !mRun) begin
        mPre = 0; mDiv = 0; mHalf = 0; mBasic = 0; mBit = 0;
      end else begin
        strobe = (mPre == (1 << mSel) - 1);
        mPre = strobe ? 0 : mPre + 1;
        mBasic = strobe;
        mBit = 0;
        if (strobe) begin
          if (mDiv == mCnt - 1) begin
            mDiv = 0; mBit = mHalf; mHalf = !mHalf;
          end else mDiv++;
        end
      end
      if (rs) mSettle = 0;
      else if (mRun && oldBasic && mSettle < 2) mSettle++;
      if (regWrEn) begin
        wsel = regWrData[3:0];
        wcnt = regWrData;
        case (regAddr)
          2'd0: mRun = regWrData[0];
          2'd1: mSel = (wsel > 11) ? 11 : wsel;
          2'd2: mCnt = (wcnt < 8) ? 8 : wcnt;
          default: ;
        endcase
      end
    end
  end

  function automatic int modelRead(input logic [1:0] a);
    case (a)
      2'd0: return int'(mRun);
      2'd1: return mSel;
      2'd2: return mCnt;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (compareOn && !done) begin
      check(basicTick === mBasic, "R2 basicTick vs model", int'(basicTick), int'(mBasic));
      check(bitTick === mBit, "R3 bitTick vs model", int'(bitTick), int'(mBit));
      check(ready === (mRun && mSettle == 2), "R8 ready vs model", int'(ready), int'(mRun && mSettle == 2));
      check(regRdData === 8'(modelRead(regAddr)), "R5 regRdData vs model", int'(regRdData), modelRead(regAddr));
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk); #1;
    regAddr = a;
    @(negedge clk);
    check(int'(regRdData) == exp, tag, int'(regRdData), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts negedges from the write edge to the first tick; write issued here
  task automatic firstTick(input logic [1:0] a, input logic [7:0] d, input bit wantBit,
                           input int exp, input string tag);
    int n;
    wrReg(a, d);
    n = 1;
    forever begin
      @(negedge clk);
      n++;
      if (wantBit ? bitTick : basicTick) break;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic bitPeriod(input int exp, input string tag);
    int n;
    while (!bitTick) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitTick);
    check(n == exp, tag, n, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check(!basicTick && !bitTick && !ready, "R1 outputs low in reset", int'({basicTick, bitTick, ready}), 0);
    #1 rst_n = 1'b1;
    rdCheck(2'd0, 0, "R1 run readback");
    rdCheck(2'd1, 0, "R1 exponent readback");
    rdCheck(2'd2, 8, "R1 count readback");

    // R5 clamp and keep
    wrReg(2'd2, 8'd3);
    rdCheck(2'd2, 8, "R5 count 3 clamps to 8");
    wrReg(2'd2, 8'd255);
    rdCheck(2'd2, 255, "R5 count 255 kept");
    // R4 clamp and upper nibble ignored
    wrReg(2'd1, 8'h0F);
    rdCheck(2'd1, 11, "R4 exponent 15 clamps to 11");
    wrReg(2'd1, 8'hA3);
    rdCheck(2'd1, 3, "R4 upper bits ignored");

    // R7 stopped: nothing ticks
    idle(40);
    check(!basicTick && !bitTick && !ready, "R7 stopped quiet", int'({basicTick, bitTick, ready}), 0);

    // Run with exponent 0, count 8
    wrReg(2'd1, 8'd0);
    wrReg(2'd2, 8'd8);
    wrReg(2'd0, 8'd1);
    bitPeriod(16, "R3 period exp0 cnt8");
    check(ready === 1'b1, "R8 ready after settle", int'(ready), 1);

    // R9 rewrite of unchanged run bit keeps ready
    wrReg(2'd0, 8'd1);
    check(ready === 1'b1, "R9 same run bit no restart", int'(ready), 1);
    // R9 unused address
    wrReg(2'd3, 8'hFF);
    rdCheck(2'd3, 0, "R9 unused address reads 0");
    rdCheck(2'd2, 8, "R9 count untouched by unused write");

    // R6 restart and first basic tick timing
    firstTick(2'd1, 8'd2, 1'b0, 5, "R6 first basic tick exp2");
    check(ready === 1'b0, "R8 ready low one tick after restart", int'(ready), 0);
    firstTick(2'd2, 8'd10, 1'b0, 5, "R6 same-exponent count write restarts");
    firstTick(2'd1, 8'd1, 1'b1, 2 * 10 * 2 + 1, "R2 first bit tick exp1 cnt10");
    bitPeriod(40, "R3 period exp1 cnt10");
    idle(7);
    firstTick(2'd2, 8'd10, 1'b1, 41, "R6 mid-period rewrite restarts");

    // R7 stop mid-stream
    wrReg(2'd0, 8'd0);
    idle(2);
    check(!ready, "R7 ready low when stopped", int'(ready), 0);
    idle(60);
    check(!basicTick && !bitTick, "R7 no ticks when stopped", int'({basicTick, bitTick}), 0);
    rdCheck(2'd2, 10, "R7 count held while stopped");

    // Largest exponent: clamp to 11, count 8
    wrReg(2'd2, 8'd8);
    wrReg(2'd0, 8'd1);
    firstTick(2'd1, 8'd15, 1'b1, 2 * 8 * 2048 + 1, "R3 first bit tick exp11");
    check(ready === 1'b1, "R8 ready at largest exponent", int'(ready), 1);
    idle(20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule